// File: doc/BRIEF.md
# Receive Data Link Formatter

This block sits behind a time-slot extractor in a T1/E1 receiver. It takes one data link bit at a time, marked by a valid strobe, and turns the stream into FIFO entries and status words. The FIFO storage is not part of the block. The block only produces the write strobe, the write data and the status push.

A 2-bit mode input picks one of four behaviours. Two of them are HDLC modes, one with a frame check and one without. In these modes the block finds flags, removes inserted zeros, detects aborts and writes whole frame bytes. The other two are transparent packing modes. They store eight or six bits per entry, aligned to the multiframe. A programmable entry count closes each transparent message with a partial-message status word and a full pulse.

A single enable input gates the block. While it is low, every counter and the frame state are held cleared.

Top module: `rx_dlink_fmt`

## Requirements
- R1: While `enable` is 0 the block makes no FIFO write, no status push and no interrupt pulse, whatever arrives on the bit inputs. Raising `enable` starts with the message count, the bit count and the frame state all cleared. After reset every output is 0.
- R2: With `mode` = 2'b10 (eight-bit packing), every 8 valid bits form one FIFO entry. The first bit received goes to bit 0 of the entry.
- R3: With `mode` = 2'b11 (six-bit packing), every 6 valid bits form one entry in bits [5:0], first bit in bit 0. Bits [7:6] of that entry are 0.
- R4: In the packing modes, a valid bit with `mf_start` high is placed in bit 0 of a fresh entry. Any partly filled entry is dropped.
- R5: In the packing modes, `fill_lim` codes 0, 1, 2 and 3 close a message after 1, 2, 4 and 8 entries. The write that closes the message also pulses `full_irq` and pushes a status word with code 2'b10.
- R6: In the HDLC modes (`mode[1]` = 0), the pattern 0x7E opens and closes a frame. Frame bytes are written LSB first. Each byte is written once the next byte has completed, and the last byte is written with the closing flag. A flag that closes an empty frame produces nothing.
- R7: In the HDLC modes, a 0 that follows five consecutive 1s inside a frame is removed from the data.
- R8: In the HDLC modes, a seventh consecutive 1 aborts the frame. If at least one byte had completed, the abort pushes a status word with code 2'b11 and `eom_irq`, and the held byte is not written. Bits are then ignored until the next flag.
- R9: With `mode` = 2'b00, a CRC-16 (polynomial x^16+x^12+x^5+1, bits taken LSB first, preset to all ones) is run over every frame byte, including the two FCS bytes. All of these bytes are written to the FIFO. The closing status word has code 2'b00 when the residue is 0xF0B8 and code 2'b01 otherwise.
- R10: With `mode` = 2'b01, no CRC is checked. Every octet-aligned frame closes with status code 2'b00 and `eom_irq`.
- R11: In either HDLC mode, a frame whose length between the flags is not a whole number of bytes closes with status code 2'b01.
- R12: Every output is registered. A write, a status push or a pulse appears in the cycle right after the clock edge that sampled the bit that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | A data link bit is present this cycle |
| bit_in | input | 1 | Data link bit |
| mf_start | input | 1 | With `bit_vld`, marks the first data link bit of a multiframe |
| mode | input | 2 | 00 HDLC with FCS, 01 HDLC without FCS, 10 eight-bit packing, 11 six-bit packing |
| enable | input | 1 | Enables receive formatting and interrupt events |
| fill_lim | input | 2 | Entries per transparent message: 1, 2, 4, 8 |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| stat_push | output | 1 | Status word push |
| stat_code | output | 2 | 00 good end, 01 bad FCS or non-octet, 10 partial message, 11 abort |
| full_irq | output | 1 | Pulse when a transparent message reaches its fill limit |
| eom_irq | output | 1 | Pulse at an HDLC frame end or abort |

## Verification
Most faults in the internal state show up at the ports one cycle after the bit that exposes them.

- A bit counter that drifts shows up as a wrong byte or a misplaced write, within one entry.
- A wrong message count moves the `full_irq` pulse off its entry. This is visible within one fill period.
- A faulty run-of-ones counter damages the frame right away. It shows as a byte that still carries a stuffed zero, a missed flag, or a false abort.
- Damaged CRC state can only be seen at the closing flag, as a wrong status code.

// File: rtl/rx_dlink_fmt.sv
module rx_dlink_fmt #(
  parameter logic [15:0] CRC_RES = 16'hF0B8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       mf_start,
  input  logic [1:0] mode,
  input  logic       enable,
  input  logic [1:0] fill_lim,
  output logic       fifo_we,
  output logic [7:0] fifo_wdata,
  output logic       stat_push,
  output logic [1:0] stat_code,
  output logic       full_irq,
  output logic       eom_irq
);
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  logic [7:0]  acc, pend;
  logic [2:0]  cnt, ones, msg_cnt;
  logic        in_frame, have_pend;
  logic [15:0] crc;

  wire        hdlc     = ~mode[1];
  wire [2:0]  last     = mode[0] ? 3'd5 : 3'd7;
  wire [3:0]  lim      = 4'd1 << fill_lim;
  wire        msg_end  = {1'b0, msg_cnt} == lim - 4'd1;
  wire [7:0]  placed   = acc | (8'(bit_in) << cnt);
  wire [7:0]  shifted  = {bit_in, acc[7:1]};
  wire        flag_hit = !bit_in && ones == 3'd6;
  wire        stuffed  = !bit_in && ones == 3'd5;
  wire        abort    = bit_in && ones == 3'd6;
  wire [15:0] crc_fin  = crc_step(crc, pend);
  wire        frame_ok = cnt == 3'd7 && (mode[0] || crc_fin == CRC_RES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; pend <= '0; cnt <= '0; ones <= '0; msg_cnt <= '0;
      in_frame <= 1'b0; have_pend <= 1'b0; crc <= '1;
      fifo_we <= 1'b0; fifo_wdata <= '0; stat_push <= 1'b0; stat_code <= '0;
      full_irq <= 1'b0; eom_irq <= 1'b0;
    end else begin
      fifo_we <= 1'b0; stat_push <= 1'b0; full_irq <= 1'b0; eom_irq <= 1'b0;
      if (!enable) begin
        acc <= '0; cnt <= '0; ones <= '0; msg_cnt <= '0;
        in_frame <= 1'b0; have_pend <= 1'b0; crc <= '1;
      end else if (bit_vld && !hdlc) begin
        if (mf_start) begin
          acc <= 8'(bit_in);
          cnt <= 3'd1;
        end else if (cnt == last) begin
          fifo_we <= 1'b1; fifo_wdata <= placed;
          acc <= '0; cnt <= '0;
          if (msg_end) begin
            msg_cnt <= '0; full_irq <= 1'b1; stat_push <= 1'b1; stat_code <= 2'b10;
          end else msg_cnt <= msg_cnt + 3'd1;
        end else begin
          acc <= placed;
          cnt <= cnt + 3'd1;
        end
      end else if (bit_vld) begin
        ones <= bit_in ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
        if (abort) begin
          if (in_frame && have_pend) begin
            stat_push <= 1'b1; stat_code <= 2'b11; eom_irq <= 1'b1;
          end
          in_frame <= 1'b0; have_pend <= 1'b0; cnt <= '0;
        end else if (flag_hit) begin
          if (in_frame && have_pend) begin
            fifo_we <= 1'b1; fifo_wdata <= pend;
            stat_push <= 1'b1; stat_code <= frame_ok ? 2'b00 : 2'b01; eom_irq <= 1'b1;
          end
          in_frame <= 1'b1; have_pend <= 1'b0; cnt <= '0; acc <= '0; crc <= '1;
        end else if (!stuffed && in_frame) begin
          if (cnt == 3'd7) begin
            if (have_pend) begin
              fifo_we <= 1'b1; fifo_wdata <= pend;
              crc <= crc_step(crc, pend);
            end
            pend <= shifted; have_pend <= 1'b1; cnt <= '0;
          end else begin
            acc <= shifted;
            cnt <= cnt + 3'd1;
          end
        end
      end
    end
  end
endmodule

module rx_dlink_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_vld,
  input logic [1:0] mode,
  input logic       enable,
  input logic       fifo_we,
  input logic [7:0] fifo_wdata,
  input logic       stat_push,
  input logic [1:0] stat_code,
  input logic       full_irq,
  input logic       eom_irq
);
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !fifo_we && !stat_push && !full_irq && !eom_irq);
  a_r3_pack6_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we && $past(mode) == 2'b11 |-> fifo_wdata[7:6] == 2'b00);
  a_r5_full_is_partial: assert property (@(posedge clk) disable iff (!rst_n)
    full_irq |-> stat_push && stat_code == 2'b10 && fifo_we && $past(mode[1]));
  a_r6_eom_is_hdlc: assert property (@(posedge clk) disable iff (!rst_n)
    eom_irq |-> stat_push && stat_code != 2'b10 && !$past(mode[1]));
  a_r8_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    stat_push && stat_code == 2'b11 |-> !fifo_we);
  a_r12_write_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> $past(bit_vld) && $past(enable));
  a_r12_status_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    stat_push |-> $past(bit_vld) && $past(enable));
endmodule

bind rx_dlink_fmt rx_dlink_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .mode(mode), .enable(enable),
  .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .stat_push(stat_push),
  .stat_code(stat_code), .full_irq(full_irq), .eom_irq(eom_irq)
);

// File: tb/rx_dlink_fmt_tb.sv
`timescale 1ns/1ps
module rx_dlink_fmt_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_vld = 1'b0, bit_in = 1'b0, mf_start = 1'b0, enable = 1'b0;
  logic [1:0] mode = 2'b10, fill_lim = 2'b11;
  logic fifo_we, stat_push, full_irq, eom_irq;
  logic [7:0] fifo_wdata;
  logic [1:0] stat_code;

  rx_dlink_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .mf_start(mf_start),
    .mode(mode), .enable(enable), .fill_lim(fill_lim), .fifo_we(fifo_we),
    .fifo_wdata(fifo_wdata), .stat_push(stat_push), .stat_code(stat_code),
    .full_irq(full_irq), .eom_irq(eom_irq)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int wr_n = 0, st_n = 0, full_n = 0, eom_n = 0, so_ones = 0;
  logic [7:0] wr_log [0:255];
  logic [1:0] st_log [0:255];

  // mode, data, expected entry
  localparam logic [17:0] VEC [0:7] = '{
    {2'b10, 8'hA5, 8'hA5}, {2'b10, 8'h3C, 8'h3C}, {2'b10, 8'h01, 8'h01},
    {2'b10, 8'h80, 8'h80}, {2'b11, 8'hFF, 8'h3F}, {2'b11, 8'h2A, 8'h2A},
    {2'b11, 8'hC5, 8'h05}, {2'b11, 8'h15, 8'h15}};

  always @(negedge clk) if (rst_n) begin
    if (fifo_we && wr_n < 256) begin wr_log[wr_n] = fifo_wdata; wr_n++; end
    if (stat_push && st_n < 256) begin st_log[st_n] = stat_code; st_n++; end
    if (full_irq) full_n++;
    if (eom_irq) eom_n++;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic mf);
    @(negedge clk); bit_vld = 1'b1; bit_in = b; mf_start = mf;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); bit_vld = 1'b0; mf_start = 1'b0; end
    #1;
  endtask

  task automatic restart(input logic [1:0] m, input logic [1:0] f);
    idle(1); enable = 1'b0; mode = m; fill_lim = f; idle(1); enable = 1'b1; idle(1);
  endtask

  task automatic send_flag();
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    so_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      send_bit(d[i], 1'b0);
      so_ones = d[i] ? so_ones + 1 : 0;
      if (so_ones == 5) begin send_bit(1'b0, 1'b0); so_ones = 0; end
    end
  endtask

  function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w0, s0, f0, e0;
    logic [15:0] c;
    idle(3); rst_n = 1'b1; idle(1);
    chk(!fifo_we && !stat_push && !full_irq && !eom_irq, "R1 reset", fifo_we, 0);

    // table of packing vectors (R2, R3)
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      int nb;
      restart(VEC[i][17:16], 2'b11);
      d = VEC[i][15:8];
      nb = VEC[i][16] ? 6 : 8;
      w0 = wr_n;
      for (int j = 0; j < nb; j++) send_bit(d[j], j == 0);
      idle(2);
      chk(wr_n == w0 + 1 && wr_log[w0] == VEC[i][7:0], VEC[i][16] ? "R3 pack6" : "R2 pack8",
          wr_log[w0], VEC[i][7:0]);
    end

    // R12 write timing
    restart(2'b10, 2'b11);
    for (int j = 0; j < 8; j++) send_bit(j[0], 1'b0);
    @(negedge clk); #1;
    chk(fifo_we && fifo_wdata == 8'hAA, "R12 timing", fifo_we, 1);
    bit_vld = 1'b0; idle(1);
    chk(!fifo_we, "R12 single pulse", fifo_we, 0);

    // R4 multiframe realignment
    restart(2'b10, 2'b11);
    w0 = wr_n;
    for (int j = 0; j < 3; j++) send_bit(1'b1, 1'b0);
    for (int j = 0; j < 8; j++) send_bit(8'h96 >> j, j == 0);
    idle(2);
    chk(wr_n == w0 + 1 && wr_log[w0] == 8'h96, "R4 realign", wr_log[w0], 8'h96);

    // R5 fill limit of 2 entries
    restart(2'b10, 2'b01);
    f0 = full_n; s0 = st_n;
    for (int k = 0; k < 4; k++) for (int j = 0; j < 8; j++) send_bit(j[1], 1'b0);
    idle(2);
    chk(full_n == f0 + 2 && st_n == s0 + 2 && st_log[s0] == 2'b10, "R5 limit2", full_n - f0, 2);
    restart(2'b11, 2'b00);
    f0 = full_n;
    for (int k = 0; k < 3; k++) for (int j = 0; j < 6; j++) send_bit(1'b0, 1'b0);
    idle(2);
    chk(full_n == f0 + 3, "R5 limit1", full_n - f0, 3);

    // R1 disabled
    idle(1); enable = 1'b0; mode = 2'b10;
    w0 = wr_n; s0 = st_n; e0 = eom_n;
    for (int j = 0; j < 16; j++) send_bit(1'b1, j == 0);
    idle(2);
    chk(wr_n == w0 && st_n == s0 && eom_n == e0, "R1 disabled", wr_n - w0, 0);

    // R6 idle flags
    restart(2'b01, 2'b00);
    w0 = wr_n; s0 = st_n;
    for (int k = 0; k < 4; k++) send_flag();
    idle(2);
    chk(wr_n == w0 && st_n == s0, "R6 idle flags", st_n - s0, 0);

    // R6 R7 R10 frame without FCS, with stuffing
    restart(2'b01, 2'b00);
    w0 = wr_n; s0 = st_n; e0 = eom_n;
    send_flag(); send_byte(8'hA5); send_byte(8'hFF); send_byte(8'h7E); send_byte(8'h3E); send_flag();
    idle(2);
    chk(wr_n == w0 + 4, "R6 byte count", wr_n - w0, 4);
    chk(wr_log[w0] == 8'hA5 && wr_log[w0+3] == 8'h3E, "R6 bytes", wr_log[w0], 8'hA5);
    chk(wr_log[w0+1] == 8'hFF && wr_log[w0+2] == 8'h7E, "R7 destuff", wr_log[w0+1], 8'hFF);
    chk(st_n == s0 + 1 && st_log[s0] == 2'b00 && eom_n == e0 + 1, "R10 no-FCS end", st_log[s0], 0);

    // R9 good FCS
    restart(2'b00, 2'b00);
    c = bcrc(bcrc(16'hFFFF, 8'h12), 8'h34); c = ~c;
    w0 = wr_n; s0 = st_n;
    send_flag(); send_byte(8'h12); send_byte(8'h34); send_byte(c[7:0]); send_byte(c[15:8]); send_flag();
    idle(2);
    chk(wr_n == w0 + 4 && st_n == s0 + 1 && st_log[s0] == 2'b00, "R9 good FCS", st_log[s0], 0);

    // R9 bad FCS
    restart(2'b00, 2'b00);
    s0 = st_n;
    send_flag(); send_byte(8'h12); send_byte(8'h34); send_byte(c[7:0] ^ 8'h01); send_byte(c[15:8]); send_flag();
    idle(2);
    chk(st_n == s0 + 1 && st_log[s0] == 2'b01, "R9 bad FCS", st_log[s0], 1);

    // R8 abort
    restart(2'b01, 2'b00);
    w0 = wr_n; s0 = st_n; e0 = eom_n;
    send_flag(); send_byte(8'h55);
    for (int j = 0; j < 8; j++) send_bit(1'b1, 1'b0);
    idle(2);
    chk(wr_n == w0 && st_n == s0 + 1 && st_log[s0] == 2'b11 && eom_n == e0 + 1, "R8 abort",
        st_log[s0], 3);

    // R11 non-octet frame
    restart(2'b01, 2'b00);
    s0 = st_n;
    send_flag(); send_byte(8'h55);
    send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
    send_flag();
    idle(2);
    chk(st_n == s0 + 1 && st_log[s0] == 2'b01, "R11 non-octet", st_log[s0], 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule